// File: doc/BRIEF.md
# Trace Table Entry Allocator

This block owns the pointer to the next free slot of a trace table. The pointer lives in an address field inside a control register. A requester that wants to write an entry of some byte size sends a reserve request. The block checks the current pointer against three fault conditions. If none applies, it returns the absolute address of the slot. If one applies, it reports the single highest-priority fault as a one-hot code. When the requester has written the entry, it sends a commit with the number of bytes actually used. The block then moves the pointer forward and produces the updated control-register value.

Software addresses are real addresses. Storage is accessed with absolute addresses. Prefix swapping converts between the two, in both directions: the 4 KB block at page zero and the 4 KB block named by the prefix page trade places, and every other address passes through unchanged. Reserve converts the real pointer to an absolute grant address. Commit converts the advanced absolute address back to a real pointer before storing it. Every result is registered, so grants, faults and the new register value appear one clock after the request.

Top module: `trace_entry_alloc`

## Requirements
- R1: In reset, cr_o is 0, grant_valid_o and exc_valid_o are 0, and exc_code_o is 3'b000.
- R2: A write (cr_wr_en_i) loads cr_wr_data_i into cr_o on the next cycle. It has priority over commit and reserve in the same cycle, and it discards any outstanding grant.
- R3: The entry address is cr_o bits [30:2] with bits [1:0] taken as zero. A reserve that raises no fault pulses grant_valid_o for one cycle, one cycle after the request, and sets grant_addr_o to the prefixed entry address.
- R4: Prefixing maps a real or absolute address in page 0 to the same offset in page prefix_page_i. It maps an address in page prefix_page_i to the same offset in page 0. All other addresses are unchanged. The same rule applies on reserve and on commit.
- R5: With lap_en_i set, an entry address in 0..511 or 4096..4607 raises the protection fault, code 3'b001. This fault takes priority over both other faults.
- R6: An entry address greater than main_limit_i raises the addressing fault, code 3'b010. This fault takes priority over the trace-table fault.
- R7: If entry address plus reserve size lies in a different 4 KB page than the entry address, the trace-table fault is raised, code 3'b100. This includes ending exactly on the next page start.
- R8: A faulting reserve pulses exc_valid_o for one cycle with exactly one code bit set and no grant. It leaves cr_o unchanged and leaves no grant outstanding.
- R9: A commit sets the cr_o field [30:2] to the prefix conversion of (granted absolute address + size), one cycle after the request. Bit 31 and bits [1:0] are kept.
- R10: A commit with no outstanding grant is ignored and cr_o is unchanged. A grant can be committed only once.
- R11: A commit size larger than the reserved size is clamped to the reserved size.
- R12: A commit request in the same cycle as a reserve request wins, and the reserve is dropped with no grant and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cr_wr_en_i | input | 1 | Load control register |
| cr_wr_data_i | input | 32 | Value to load |
| prefix_page_i | input | 19 | Prefix page frame number |
| main_limit_i | input | 31 | Highest valid storage address |
| lap_en_i | input | 1 | Low-address protection enable |
| rsv_req_i | input | 1 | Reserve request |
| rsv_size_i | input | 8 | Reserve size in bytes |
| cmt_req_i | input | 1 | Commit request |
| cmt_size_i | input | 8 | Bytes used by the entry |
| grant_valid_o | output | 1 | Grant pulse |
| grant_addr_o | output | 31 | Absolute address of granted slot |
| exc_valid_o | output | 1 | Fault pulse |
| exc_code_o | output | 3 | One-hot fault: bit0 protection, bit1 addressing, bit2 trace table |
| cr_o | output | 32 | Current control-register value |

## Verification
Reserves are tried with pointers in page 0, in the prefix page and in an ordinary page. This separates the three prefix cases, and commits from the same pages check the reverse mapping. Pointers on each side of the two protected windows, the storage limit and the page end separate each fault from its neighbour. Pointers that trip two faults at once expose the priority order. Sequences that commit twice, commit with no grant, commit oversized, or collide a reserve with a commit or a write separate the outstanding-grant bookkeeping from the pointer arithmetic.

// File: rtl/trace_alloc_pkg.sv
// Shared fault encoding for the trace entry allocator.
package trace_alloc_pkg;
    typedef enum logic [2:0] {
        FAULT_NONE  = 3'b000,
        FAULT_PROT  = 3'b001,
        FAULT_ADDR  = 3'b010,
        FAULT_TABLE = 3'b100
    } fault_e;
endpackage

// File: rtl/trace_alloc_prefix.sv
// Prefix swap: exchanges page 0 with the prefix page; the mapping is its
// own inverse, so one unit serves real->absolute and absolute->real.
// Assumes ADDR_W > PAGE_W.
module trace_alloc_prefix #(
    parameter int ADDR_W = 31,
    parameter int PAGE_W = 12
) (
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [ADDR_W-PAGE_W-1:0] pfx_page_i,
    output logic [ADDR_W-1:0]        addr_o
);
    localparam int PN_W = ADDR_W - PAGE_W;

    logic [PN_W-1:0] in_page;
    assign in_page = addr_i[ADDR_W-1:PAGE_W];

    // Select the swapped or unchanged page number.
    always_comb begin
        if (in_page == '0) begin
            addr_o = {pfx_page_i, addr_i[PAGE_W-1:0]};
        end else if (in_page == pfx_page_i) begin
            addr_o = {{PN_W{1'b0}}, addr_i[PAGE_W-1:0]};
        end else begin
            addr_o = addr_i;
        end
    end
endmodule

// File: rtl/trace_alloc_check.sv
// Fault evaluation for a candidate entry: protection, then addressing,
// then page crossing. Assumes the protected windows start at 0 and at
// one page above 0, each LAP_SPAN bytes long.
module trace_alloc_check
    import trace_alloc_pkg::*;
#(
    parameter int ADDR_W   = 31,
    parameter int SIZE_W   = 8,
    parameter int PAGE_W   = 12,
    parameter int LAP_SPAN = 512
) (
    input  logic [ADDR_W-1:0] entry_addr_i,
    input  logic [SIZE_W-1:0] entry_size_i,
    input  logic              lap_en_i,
    input  logic [ADDR_W-1:0] main_limit_i,
    output fault_e            fault_o
);
    localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(LAP_SPAN);
    localparam logic [ADDR_W-1:0] HIGH_BEG = ADDR_W'(1 << PAGE_W);
    localparam logic [ADDR_W-1:0] HIGH_END = ADDR_W'((1 << PAGE_W) + LAP_SPAN);

    logic [ADDR_W:0] end_addr;
    logic            lap_hit;
    logic            over_limit;
    logic            crosses;

    // Compute end address one bit wider so a wrap also counts as a crossing.
    assign end_addr   = {1'b0, entry_addr_i} + (ADDR_W+1)'(entry_size_i);
    assign crosses    = end_addr[ADDR_W:PAGE_W] != {1'b0, entry_addr_i[ADDR_W-1:PAGE_W]};
    assign over_limit = entry_addr_i > main_limit_i;
    assign lap_hit    = lap_en_i &&
                        ((entry_addr_i < LOW_END) ||
                         ((entry_addr_i >= HIGH_BEG) && (entry_addr_i < HIGH_END)));

    // Fixed-priority selection of the single reported fault.
    always_comb begin
        if (lap_hit) begin
            fault_o = FAULT_PROT;
        end else if (over_limit) begin
            fault_o = FAULT_ADDR;
        end else if (crosses) begin
            fault_o = FAULT_TABLE;
        end else begin
            fault_o = FAULT_NONE;
        end
    end
endmodule

// File: rtl/trace_alloc_state.sv
// State of the allocator: control register, outstanding-grant flag,
// held grant address and size, and the registered result pulses.
// Assumes the caller decodes mutually exclusive actions.
module trace_alloc_state
    import trace_alloc_pkg::*;
#(
    parameter int CR_W   = 32,
    parameter int ADDR_W = 31,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en_i,
    input  logic [CR_W-1:0]   load_val_i,
    input  logic              commit_en_i,
    input  logic [CR_W-1:0]   commit_val_i,
    input  logic              grant_en_i,
    input  logic [ADDR_W-1:0] grant_addr_i,
    input  logic [SIZE_W-1:0] grant_size_i,
    input  logic              fault_en_i,
    input  fault_e            fault_i,
    output logic [CR_W-1:0]   cr_q,
    output logic              open_q,
    output logic [ADDR_W-1:0] held_addr_q,
    output logic [SIZE_W-1:0] held_size_q,
    output logic              grant_pulse_q,
    output logic              fault_pulse_q,
    output logic [2:0]        fault_code_q
);
    // Control register update: load wins, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
        end else if (load_en_i) begin
            cr_q <= load_val_i;
        end else if (commit_en_i) begin
            cr_q <= commit_val_i;
        end
    end

    // Outstanding-grant flag: set by a grant, cleared by anything else that acts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (load_en_i || commit_en_i || fault_en_i) begin
            open_q <= 1'b0;
        end else if (grant_en_i) begin
            open_q <= 1'b1;
        end
    end

    // Hold the granted absolute address and reserved size for the commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr_q <= '0;
            held_size_q <= '0;
        end else if (grant_en_i) begin
            held_addr_q <= grant_addr_i;
            held_size_q <= grant_size_i;
        end
    end

    // One-cycle result pulses and the fault code that goes with them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_pulse_q <= 1'b0;
            fault_pulse_q <= 1'b0;
            fault_code_q  <= FAULT_NONE;
        end else begin
            grant_pulse_q <= grant_en_i;
            fault_pulse_q <= fault_en_i;
            fault_code_q  <= fault_en_i ? fault_i : FAULT_NONE;
        end
    end
endmodule

// File: rtl/trace_entry_alloc.sv
// Trace table entry allocator top. Reserve checks the pointer in the
// control register field [ADDR_W-1:FIELD_LO] and grants a prefixed
// absolute address or reports a fault. Commit advances the held address,
// converts it back to real, and merges it into the control register.
// Assumes CR_W >= ADDR_W and that prefix_page_i is stable between a
// reserve and its commit.
module trace_entry_alloc
    import trace_alloc_pkg::*;
#(
    parameter int CR_W     = 32,
    parameter int ADDR_W   = 31,
    parameter int FIELD_LO = 2,
    parameter int SIZE_W   = 8,
    parameter int PAGE_W   = 12,
    parameter int LAP_SPAN = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cr_wr_en_i,
    input  logic [CR_W-1:0]          cr_wr_data_i,
    input  logic [ADDR_W-PAGE_W-1:0] prefix_page_i,
    input  logic [ADDR_W-1:0]        main_limit_i,
    input  logic                     lap_en_i,
    input  logic                     rsv_req_i,
    input  logic [SIZE_W-1:0]        rsv_size_i,
    input  logic                     cmt_req_i,
    input  logic [SIZE_W-1:0]        cmt_size_i,
    output logic                     grant_valid_o,
    output logic [ADDR_W-1:0]        grant_addr_o,
    output logic                     exc_valid_o,
    output logic [2:0]               exc_code_o,
    output logic [CR_W-1:0]          cr_o
);
    localparam logic [CR_W-1:0] FIELD_MASK =
        ({CR_W{1'b1}} >> (CR_W - ADDR_W)) & ({CR_W{1'b1}} << FIELD_LO);

    logic [CR_W-1:0]   cr_q;
    logic              open_q;
    logic [ADDR_W-1:0] held_addr_q;
    logic [SIZE_W-1:0] held_size_q;
    logic [ADDR_W-1:0] entry_real;
    logic [ADDR_W-1:0] entry_abs;
    logic [SIZE_W-1:0] used_size;
    logic [ADDR_W-1:0] next_abs;
    logic [ADDR_W-1:0] next_real;
    logic [CR_W-1:0]   cr_commit;
    fault_e            fault;
    logic              act_commit;
    logic              act_rsv;
    logic              act_grant;
    logic              act_fault;

    // Entry address is the masked field of the control register.
    assign entry_real = cr_q[ADDR_W-1:0] & FIELD_MASK[ADDR_W-1:0];

    // Action decode: write beats commit, commit request beats reserve.
    assign act_commit = !cr_wr_en_i && cmt_req_i && open_q;
    assign act_rsv    = !cr_wr_en_i && !cmt_req_i && rsv_req_i;
    assign act_grant  = act_rsv && (fault == FAULT_NONE);
    assign act_fault  = act_rsv && (fault != FAULT_NONE);

    // Clamp the committed size to what was reserved.
    assign used_size  = (cmt_size_i > held_size_q) ? held_size_q : cmt_size_i;
    assign next_abs   = held_addr_q + ADDR_W'(used_size);

    // Merge the new real pointer into the field, keeping all other bits.
    assign cr_commit  = (cr_q & ~FIELD_MASK) |
                        ({{(CR_W-ADDR_W){1'b0}}, next_real} & FIELD_MASK);

    trace_alloc_check #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .PAGE_W   (PAGE_W),
        .LAP_SPAN (LAP_SPAN)
    ) u_check (
        .entry_addr_i (entry_real),
        .entry_size_i (rsv_size_i),
        .lap_en_i     (lap_en_i),
        .main_limit_i (main_limit_i),
        .fault_o      (fault)
    );

    trace_alloc_prefix #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_to_abs (
        .addr_i     (entry_real),
        .pfx_page_i (prefix_page_i),
        .addr_o     (entry_abs)
    );

    trace_alloc_prefix #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_to_real (
        .addr_i     (next_abs),
        .pfx_page_i (prefix_page_i),
        .addr_o     (next_real)
    );

    trace_alloc_state #(
        .CR_W   (CR_W),
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W)
    ) u_state (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_en_i     (cr_wr_en_i),
        .load_val_i    (cr_wr_data_i),
        .commit_en_i   (act_commit),
        .commit_val_i  (cr_commit),
        .grant_en_i    (act_grant),
        .grant_addr_i  (entry_abs),
        .grant_size_i  (rsv_size_i),
        .fault_en_i    (act_fault),
        .fault_i       (fault),
        .cr_q          (cr_q),
        .open_q        (open_q),
        .held_addr_q   (held_addr_q),
        .held_size_q   (held_size_q),
        .grant_pulse_q (grant_valid_o),
        .fault_pulse_q (exc_valid_o),
        .fault_code_q  (exc_code_o)
    );

    assign grant_addr_o = held_addr_q;
    assign cr_o         = cr_q;
endmodule

// File: rtl/trace_entry_alloc_chk.sv
// Port-level checker for the trace entry allocator, bound to every instance.
module trace_entry_alloc_chk #(
    parameter int CR_W     = 32,
    parameter int ADDR_W   = 31,
    parameter int FIELD_LO = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cr_wr_en_i,
    input logic [CR_W-1:0] cr_wr_data_i,
    input logic            rsv_req_i,
    input logic            cmt_req_i,
    input logic            grant_valid_o,
    input logic            exc_valid_o,
    input logic [2:0]      exc_code_o,
    input logic [CR_W-1:0] cr_o
);
    localparam logic [CR_W-1:0] KEEP_MASK =
        ~(({CR_W{1'b1}} >> (CR_W - ADDR_W)) & ({CR_W{1'b1}} << FIELD_LO));

    assert_grant_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid_o && exc_valid_o));

    assert_fault_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> ($countones(exc_code_o) == 1));

    assert_code_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid_o |-> (exc_code_o == 3'b000));

    assert_fault_keeps_cr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid_o |-> $stable(cr_o));

    assert_grant_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> $past(rsv_req_i && !cmt_req_i && !cr_wr_en_i));

    assert_cr_change_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cr_o) |-> $past(cr_wr_en_i || cmt_req_i));

    assert_commit_keeps_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmt_req_i) && !$past(cr_wr_en_i)) |->
        ((cr_o & KEEP_MASK) == ($past(cr_o) & KEEP_MASK)));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cr_wr_en_i) |-> (cr_o == $past(cr_wr_data_i)));
endmodule

bind trace_entry_alloc trace_entry_alloc_chk #(
    .CR_W     (CR_W),
    .ADDR_W   (ADDR_W),
    .FIELD_LO (FIELD_LO)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cr_wr_en_i    (cr_wr_en_i),
    .cr_wr_data_i  (cr_wr_data_i),
    .rsv_req_i     (rsv_req_i),
    .cmt_req_i     (cmt_req_i),
    .grant_valid_o (grant_valid_o),
    .exc_valid_o   (exc_valid_o),
    .exc_code_o    (exc_code_o),
    .cr_o          (cr_o)
);

// File: tb/trace_entry_alloc_tb.sv
`timescale 1ns/1ps
module trace_entry_alloc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_wr_en = 1'b0;
    logic [31:0] cr_wr_data = '0;
    logic [18:0] pfx_page = 19'h00020;
    logic [30:0] limit = 31'h00FF_FFFF;
    logic        lap_en = 1'b0;
    logic        rsv_req = 1'b0;
    logic [7:0]  rsv_size = '0;
    logic        cmt_req = 1'b0;
    logic [7:0]  cmt_size = '0;
    logic        grant_valid;
    logic [30:0] grant_addr;
    logic        exc_valid;
    logic [2:0]  exc_code;
    logic [31:0] cr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    trace_entry_alloc u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cr_wr_en_i    (cr_wr_en),
        .cr_wr_data_i  (cr_wr_data),
        .prefix_page_i (pfx_page),
        .main_limit_i  (limit),
        .lap_en_i      (lap_en),
        .rsv_req_i     (rsv_req),
        .rsv_size_i    (rsv_size),
        .cmt_req_i     (cmt_req),
        .cmt_size_i    (cmt_size),
        .grant_valid_o (grant_valid),
        .grant_addr_o  (grant_addr),
        .exc_valid_o   (exc_valid),
        .exc_code_o    (exc_code),
        .cr_o          (cr)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic write_cr(input logic [31:0] v);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_data = v;
        @(negedge clk);
        cr_wr_en = 1'b0;
        chk("R2", "cr after write", cr, v);
    endtask

    // Reserve and check the grant or fault one cycle later.
    task automatic reserve(input string tag, input logic [7:0] sz,
                           input logic [2:0] exp_code, input logic [30:0] exp_addr);
        @(negedge clk);
        rsv_req = 1'b1; rsv_size = sz;
        @(negedge clk);
        rsv_req = 1'b0;
        chk(tag, "grant_valid", {31'd0, grant_valid}, {31'd0, exp_code == 3'b000});
        chk(tag, "exc_valid", {31'd0, exc_valid}, {31'd0, exp_code != 3'b000});
        chk(tag, "exc_code", {29'd0, exc_code}, {29'd0, exp_code});
        if (exp_code == 3'b000) chk(tag, "grant_addr", {1'b0, grant_addr}, {1'b0, exp_addr});
    endtask

    task automatic commit(input string tag, input logic [7:0] sz, input logic [31:0] exp_cr);
        @(negedge clk);
        cmt_req = 1'b1; cmt_size = sz;
        @(negedge clk);
        cmt_req = 1'b0;
        chk(tag, "cr after commit", cr, exp_cr);
    endtask

    task automatic t_reset;
        chk("R1", "cr", cr, 32'h0);
        chk("R1", "grant_valid", {31'd0, grant_valid}, 32'h0);
        chk("R1", "exc_valid", {31'd0, exc_valid}, 32'h0);
        chk("R1", "exc_code", {29'd0, exc_code}, 32'h0);
    endtask

    task automatic t_plain;
        write_cr(32'h8000_5101);
        reserve("R3", 8'd16, 3'b000, 31'h5100);
        commit("R9", 8'd16, 32'h8000_5111);
    endtask

    task automatic t_prefix;
        write_cr(32'h0000_0040);
        reserve("R4", 8'd8, 3'b000, 31'h2_0040);
        commit("R4", 8'd8, 32'h0000_0048);
        write_cr(32'h0002_0100);
        reserve("R4", 8'd12, 3'b000, 31'h100);
        commit("R4", 8'd12, 32'h0002_010C);
    endtask

    task automatic t_protect;
        lap_en = 1'b1;
        write_cr(32'h0000_0100);
        reserve("R5", 8'd8, 3'b001, '0);
        write_cr(32'h0000_11F0);
        reserve("R5", 8'd8, 3'b001, '0);
        write_cr(32'h0000_1200);
        reserve("R5", 8'd8, 3'b000, 31'h1200);
        write_cr(32'h0000_0200);
        reserve("R5", 8'd8, 3'b000, 31'h2_0200);
        limit = 31'h50;
        write_cr(32'h0000_0100);
        reserve("R5", 8'd8, 3'b001, '0);
        limit = 31'h00FF_FFFF;
        lap_en = 1'b0;
    endtask

    task automatic t_addressing;
        write_cr(32'h0100_0000);
        reserve("R6", 8'd8, 3'b010, '0);
        write_cr(32'h0100_0FF8);
        reserve("R6", 8'd16, 3'b010, '0);
    endtask

    task automatic t_table;
        write_cr(32'h00FF_FFF0);
        reserve("R7", 8'd16, 3'b100, '0);
        write_cr(32'h0000_5FF8);
        reserve("R7", 8'd8, 3'b100, '0);
        reserve("R7", 8'd4, 3'b000, 31'h5FF8);
    endtask

    task automatic t_fault_effects;
        write_cr(32'h8000_7FF2);
        reserve("R8", 8'd8, 3'b000, 31'h7FF0);
        reserve("R8", 8'd16, 3'b100, '0);
        chk("R8", "cr after fault", cr, 32'h8000_7FF2);
        commit("R8", 8'd4, 32'h8000_7FF2);
    endtask

    task automatic t_commit_rules;
        write_cr(32'h0000_5200);
        commit("R10", 8'd8, 32'h0000_5200);
        reserve("R10", 8'd8, 3'b000, 31'h5200);
        commit("R10", 8'd8, 32'h0000_5208);
        commit("R10", 8'd8, 32'h0000_5208);
        reserve("R11", 8'd8, 3'b000, 31'h5208);
        commit("R11", 8'd40, 32'h0000_5210);
    endtask

    task automatic t_collide;
        reserve("R12", 8'd8, 3'b000, 31'h5210);
        @(negedge clk);
        rsv_req = 1'b1; rsv_size = 8'd8; cmt_req = 1'b1; cmt_size = 8'd8;
        @(negedge clk);
        rsv_req = 1'b0; cmt_req = 1'b0;
        chk("R12", "no grant on collision", {31'd0, grant_valid}, 32'h0);
        chk("R12", "no fault on collision", {31'd0, exc_valid}, 32'h0);
        chk("R12", "commit wins", cr, 32'h0000_5218);
        reserve("R2", 8'd8, 3'b000, 31'h5218);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_data = 32'h0000_6000; cmt_req = 1'b1; cmt_size = 8'd8;
        @(negedge clk);
        cr_wr_en = 1'b0; cmt_req = 1'b0;
        chk("R2", "write beats commit", cr, 32'h0000_6000);
        commit("R2", 8'd8, 32'h0000_6000);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_wr_data = 32'h0000_6100; rsv_req = 1'b1; rsv_size = 8'd8;
        @(negedge clk);
        cr_wr_en = 1'b0; rsv_req = 1'b0;
        chk("R2", "no grant with write", {31'd0, grant_valid}, 32'h0);
        chk("R2", "write beats reserve", cr, 32'h0000_6100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_plain;
        t_prefix;
        t_protect;
        t_addressing;
        t_table;
        t_fault_effects;
        t_commit_rules;
        t_collide;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule